// File: doc/BRIEF.md
# Priority Interrupt Presentation Controller

This block collects edge events from a small group of interrupt sources and presents at most one of them at a time to a single processor. Every source carries an 8-bit priority from a configuration input. A smaller number is more urgent. The value 0xFF disables the source. The processor holds a current-priority register. A source is offered only when its priority is strictly more urgent than that register.

The processor takes an interrupt with an acknowledge read. The read returns the source number (index plus one, with zero meaning "nothing") and the register value that held before the read. The register then moves to the taken source's priority, and that source stays masked. An end-of-interrupt command names a source and unmasks it. It also writes a new priority, which is accepted only if it is equal or less urgent. Software may also write the register directly at any time. If a presented source stops qualifying because the register changed, it is rejected. Its own state machine returns it to pending so that it retries later.

Top module: `irq_present_ctrl`

## Requirements
- R1: A source is presented only when its priority is numerically below the current-priority register; equal priority does not qualify.
- R2: Among qualifying pending sources, the lowest priority value wins and a tie goes to the lowest source index; only one source is presented at a time.
- R3: An acknowledge read while a source is presented returns, one cycle later with `ack_vld` high, `ack_src` = index+1 and `ack_prev_prio` = the register before the read; the register becomes that source's priority.
- R4: An acknowledge read with nothing presented returns `ack_src` = 0 and leaves the register unchanged.
- R5: An acknowledged source is not presented again until an end-of-interrupt names its number.
- R6: End-of-interrupt loads `eoi_prio` only if it is numerically greater than or equal to the register; a more urgent value is ignored. The command returns the named acknowledged source to idle.
- R7: A direct write `cppr_wr` loads any value into the register, so that equal-level sources can be accepted before end-of-interrupt.
- R8: A presented source whose priority no longer qualifies is withdrawn, goes back to pending, and is presented again once it qualifies.
- R9: Sources react to rising edges. An edge that arrives while a source awaits end-of-interrupt is lost and not replayed. An edge while the source is already pending adds nothing.
- R10: A source whose priority is 0xFF is never presented.
- R11: After reset the register is 0xFF, `irq_out` is low and `ack_src` is 0.
- R12: `irq_out` is a level that stays high while a presented source is not yet acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NUM_SRC | Event lines, rising edge raises an interrupt |
| cfg_prio | input | NUM_SRC*8 | Packed per-source priorities, source i at bits [8i+7:8i] |
| ack_rd | input | 1 | Acknowledge read strobe |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_src | input | SRC_W | Source number (index+1) retired by end-of-interrupt |
| eoi_prio | input | 8 | Priority to restore with end-of-interrupt |
| cppr_wr | input | 1 | Direct current-priority write strobe |
| cppr_wdata | input | 8 | Value for the direct write |
| irq_out | output | 1 | Interrupt request level to the processor |
| cppr | output | 8 | Current-priority register |
| ack_vld | output | 1 | Acknowledge result valid (one cycle) |
| ack_src | output | SRC_W | Acknowledged source number, 0 when none |
| ack_prev_prio | output | 8 | Register value before the acknowledge |

## Verification
The bench builds the block with four sources. Two of them share priority 0x20, one uses 0x40 and one is disabled at 0xFF. This puts the tie-break, the strict-compare boundary at equal priority and the disabled path within reach of one short sequence. Each acknowledge result is queued as expected and compared as it comes out. The sequence covers register writes that reject a presented source and then let it retry, end-of-interrupt values that try to raise urgency, and edges lost while a source is masked.

// File: rtl/irq_pc_pkg.sv
package irq_pc_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_PEND = 2'd1,
    SRC_PRES = 2'd2,
    SRC_ACTV = 2'd3
  } src_st_e;

  // a source may be offered only when enabled and strictly more urgent
  function automatic logic prio_qualifies(input logic [PRIO_W-1:0] p,
                                          input logic [PRIO_W-1:0] cur);
    return (p != PRIO_OFF) && (p < cur);
  endfunction

  // end-of-interrupt may only make the processor less urgent
  function automatic logic [PRIO_W-1:0] eoi_restore(input logic [PRIO_W-1:0] cur,
                                                    input logic [PRIO_W-1:0] req);
    return (req >= cur) ? req : cur;
  endfunction
endpackage

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
  import irq_pc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_edge,
  input  logic qualify,
  input  logic present_go,
  input  logic ack_take,
  input  logic eoi_hit,
  output logic cand,
  output logic pres
);
  src_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SRC_IDLE: if (evt_edge) st_d = SRC_PEND;
      SRC_PEND: if (present_go) st_d = SRC_PRES;
      SRC_PRES: begin
        if (ack_take) st_d = SRC_ACTV;
        else if (!qualify) st_d = SRC_PEND;   // reject, retry later
      end
      SRC_ACTV: if (eoi_hit) st_d = SRC_IDLE; // edges here are lost
      default:  st_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SRC_IDLE;
    else        st_q <= st_d;
  end

  assign cand = (st_q == SRC_PEND) && qualify;
  assign pres = (st_q == SRC_PRES);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_pc_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      sel_vld,
  output logic [IDX_W-1:0]          sel_idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    sel_vld = 1'b0;
    sel_idx = '0;
    best    = PRIO_OFF;
    for (int i = 0; i < NUM_SRC; i++) begin
      // strict compare keeps the lowest index on a tie
      if (cand[i] && (!sel_vld || prio_flat[i*PRIO_W +: PRIO_W] < best)) begin
        sel_vld = 1'b1;
        sel_idx = IDX_W'(i);
        best    = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl
  import irq_pc_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int SRC_W = $clog2(NUM_SRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_evt,
  input  logic [NUM_SRC*PRIO_W-1:0] cfg_prio,
  input  logic                      ack_rd,
  input  logic                      eoi_wr,
  input  logic [SRC_W-1:0]          eoi_src,
  input  logic [PRIO_W-1:0]         eoi_prio,
  input  logic                      cppr_wr,
  input  logic [PRIO_W-1:0]         cppr_wdata,
  output logic                      irq_out,
  output logic [PRIO_W-1:0]         cppr,
  output logic                      ack_vld,
  output logic [SRC_W-1:0]          ack_src,
  output logic [PRIO_W-1:0]         ack_prev_prio
);
  logic [NUM_SRC-1:0] evt_prev_q, evt_edge;
  logic [NUM_SRC-1:0] qualify, cand, pres_vec, present_go, ack_take, eoi_hit;
  logic               sel_vld, any_pres, ack_hit;
  logic [IDX_W-1:0]   sel_idx, pres_idx;
  logic [PRIO_W-1:0]  pres_prio, cppr_q;

  assign evt_edge = src_evt & ~evt_prev_q;
  assign any_pres = |pres_vec;
  assign ack_hit  = ack_rd && any_pres;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign qualify[g]    = prio_qualifies(cfg_prio[g*PRIO_W +: PRIO_W], cppr_q);
    assign present_go[g] = !any_pres && sel_vld && (sel_idx == IDX_W'(g));
    assign ack_take[g]   = ack_rd && pres_vec[g];
    assign eoi_hit[g]    = eoi_wr && (eoi_src == SRC_W'(g + 1));

    irq_src_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_edge   (evt_edge[g]),
      .qualify    (qualify[g]),
      .present_go (present_go[g]),
      .ack_take   (ack_take[g]),
      .eoi_hit    (eoi_hit[g]),
      .cand       (cand[g]),
      .pres       (pres_vec[g])
    );
  end

  irq_prio_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .cand      (cand),
    .prio_flat (cfg_prio),
    .sel_vld   (sel_vld),
    .sel_idx   (sel_idx)
  );

  always_comb begin
    pres_idx  = '0;
    pres_prio = PRIO_OFF;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pres_vec[i]) begin
        pres_idx  = IDX_W'(i);
        pres_prio = cfg_prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_prev_q    <= '0;
      cppr_q        <= PRIO_OFF;
      ack_vld       <= 1'b0;
      ack_src       <= '0;
      ack_prev_prio <= PRIO_OFF;
    end else begin
      evt_prev_q <= src_evt;
      ack_vld    <= ack_rd;
      if (ack_rd) begin
        ack_src       <= ack_hit ? (SRC_W'(pres_idx) + SRC_W'(1)) : '0;
        ack_prev_prio <= cppr_q;
      end
      if (ack_hit)      cppr_q <= pres_prio;
      else if (eoi_wr)  cppr_q <= eoi_restore(cppr_q, eoi_prio);
      else if (cppr_wr) cppr_q <= cppr_wdata;
    end
  end

  assign cppr    = cppr_q;
  assign irq_out = any_pres;
endmodule

// File: rtl/irq_pc_chk.sv
module irq_pc_chk
  import irq_pc_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int SRC_W = $clog2(NUM_SRC + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ack_rd,
  input logic                      eoi_wr,
  input logic                      cppr_wr,
  input logic [PRIO_W-1:0]         eoi_prio,
  input logic [PRIO_W-1:0]         cppr,
  input logic                      irq_out,
  input logic                      ack_vld,
  input logic [SRC_W-1:0]          ack_src,
  input logic [PRIO_W-1:0]         ack_prev_prio,
  input logic [NUM_SRC-1:0]        pres_vec,
  input logic [NUM_SRC*PRIO_W-1:0] cfg_prio
);
  assert_single_presented_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pres_vec));

  assert_ack_prev_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && irq_out |=> ack_vld && (ack_src != '0) && (ack_prev_prio == $past(cppr)));

  assert_ack_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd && !irq_out && !eoi_wr && !cppr_wr |=> (ack_src == '0) && $stable(cppr));

  assert_eoi_no_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && !ack_rd && (eoi_prio < cppr) |=> $stable(cppr));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pres_vec[g] |-> (cfg_prio[g*PRIO_W +: PRIO_W] != PRIO_OFF));

    assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pres_vec[g] && !ack_rd && (cfg_prio[g*PRIO_W +: PRIO_W] >= cppr) |=> !pres_vec[g]);
  end
endmodule

bind irq_present_ctrl irq_pc_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ack_rd        (ack_rd),
  .eoi_wr        (eoi_wr),
  .cppr_wr       (cppr_wr),
  .eoi_prio      (eoi_prio),
  .cppr          (cppr),
  .irq_out       (irq_out),
  .ack_vld       (ack_vld),
  .ack_src       (ack_src),
  .ack_prev_prio (ack_prev_prio),
  .pres_vec      (pres_vec),
  .cfg_prio      (cfg_prio)
);

// File: tb/irq_present_ctrl_tb.sv
module irq_present_ctrl_tb_top;
  localparam int NUM_SRC = 4;
  localparam int SRC_W = $clog2(NUM_SRC + 1);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NUM_SRC-1:0]   src_evt = '0;
  logic [NUM_SRC*8-1:0] cfg_prio;
  logic                 ack_rd = 1'b0, eoi_wr = 1'b0, cppr_wr = 1'b0;
  logic [SRC_W-1:0]     eoi_src = '0;
  logic [7:0]           eoi_prio = '0, cppr_wdata = '0;
  logic                 irq_out, ack_vld;
  logic [7:0]           cppr, ack_prev_prio;
  logic [SRC_W-1:0]     ack_src;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [SRC_W+7:0] exp_q[$];

  always #2.5 clk = ~clk;

  // source0 = 0x40, source1 = source2 = 0x20, source3 disabled
  assign cfg_prio = {8'hFF, 8'h20, 8'h20, 8'h40};

  irq_present_ctrl #(.NUM_SRC(NUM_SRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .cfg_prio(cfg_prio),
    .ack_rd(ack_rd), .eoi_wr(eoi_wr), .eoi_src(eoi_src), .eoi_prio(eoi_prio),
    .cppr_wr(cppr_wr), .cppr_wdata(cppr_wdata), .irq_out(irq_out), .cppr(cppr),
    .ack_vld(ack_vld), .ack_src(ack_src), .ack_prev_prio(ack_prev_prio)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [NUM_SRC-1:0] m);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  // driver: the expected acknowledge result goes into the scoreboard queue
  task automatic do_ack(input int exp_src, input int exp_prev);
    exp_q.push_back({SRC_W'(exp_src), 8'(exp_prev)});
    ack_rd = 1'b1;
    @(negedge clk);
    ack_rd = 1'b0;
  endtask

  task automatic do_eoi(input int s, input int p);
    eoi_src = SRC_W'(s); eoi_prio = 8'(p); eoi_wr = 1'b1;
    @(negedge clk);
    eoi_wr = 1'b0;
  endtask

  task automatic do_cppr(input int p);
    cppr_wdata = 8'(p); cppr_wr = 1'b1;
    @(negedge clk);
    cppr_wr = 1'b0;
  endtask

  // monitor: compares every acknowledge result with the queue head
  always @(negedge clk) begin
    if (rst_n && ack_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected ack", int'(ack_src), 0);
      end else begin
        logic [SRC_W+7:0] e;
        e = exp_q.pop_front();
        chk(ack_src == e[SRC_W+7:8], "R3/R4 ack_src", int'(ack_src), int'(e[SRC_W+7:8]));
        chk(ack_prev_prio == e[7:0], "R3/R4 ack_prev_prio", int'(ack_prev_prio), int'(e[7:0]));
      end
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R11 reset state
    chk(cppr == 8'hFF, "R11 cppr", int'(cppr), 'hFF);
    chk(irq_out == 1'b0, "R11 irq_out", int'(irq_out), 0);
    chk(ack_src == '0, "R11 ack_src", int'(ack_src), 0);

    // R4 acknowledge with nothing presented
    do_ack(0, 'hFF);
    wait_cyc(1);
    chk(cppr == 8'hFF, "R4 cppr unchanged", int'(cppr), 'hFF);

    // R10 disabled source never presented
    pulse_evt(4'b1000);
    wait_cyc(3);
    chk(irq_out == 1'b0, "R10 disabled source", int'(irq_out), 0);

    // R2 tie on 0x20 goes to source index 1 (number 2)
    pulse_evt(4'b0111);
    wait_cyc(2);
    chk(irq_out == 1'b1, "R2 irq presented", int'(irq_out), 1);
    do_ack(2, 'hFF);
    wait_cyc(2);
    chk(cppr == 8'h20, "R3 cppr raised", int'(cppr), 'h20);
    chk(irq_out == 1'b0, "R1 equal priority blocked", int'(irq_out), 0);

    // R7 direct write lets the equal-level source through
    do_cppr('h30);
    wait_cyc(2);
    chk(irq_out == 1'b1, "R7 equal level accepted", int'(irq_out), 1);
    do_ack(3, 'h30);
    wait_cyc(1);
    chk(cppr == 8'h20, "R3 cppr after second ack", int'(cppr), 'h20);

    // R6 more urgent restore ignored, but source 3 is unmasked
    do_eoi(3, 'h10);
    wait_cyc(1);
    chk(cppr == 8'h20, "R6 urgent restore ignored", int'(cppr), 'h20);
    pulse_evt(4'b0100);   // source 3 pending again, 0x20 not < 0x20
    pulse_evt(4'b0010);   // source 2 still masked: edge lost (R9)
    wait_cyc(2);
    chk(irq_out == 1'b0, "R1 pending at equal level", int'(irq_out), 0);

    // R6 restore to 0xFF, source 3 presented, R12 level holds
    do_eoi(2, 'hFF);
    wait_cyc(2);
    chk(cppr == 8'hFF, "R6 restore accepted", int'(cppr), 'hFF);
    chk(irq_out == 1'b1, "R12 irq asserted", int'(irq_out), 1);
    wait_cyc(4);
    chk(irq_out == 1'b1, "R12 irq held until ack", int'(irq_out), 1);

    // R8 reject and retry
    do_cppr('h20);
    wait_cyc(2);
    chk(irq_out == 1'b0, "R8 rejected", int'(irq_out), 0);
    do_cppr('hFF);
    wait_cyc(2);
    chk(irq_out == 1'b1, "R8 retried", int'(irq_out), 1);
    do_ack(3, 'hFF);   // source 2 not replayed (R9)
    wait_cyc(1);

    // source 1 (0x40) after restore to 0x50
    do_eoi(3, 'h50);
    wait_cyc(2);
    chk(cppr == 8'h50, "R6 less urgent restore", int'(cppr), 'h50);
    chk(irq_out == 1'b1, "R1 0x40 below 0x50", int'(irq_out), 1);
    do_ack(1, 'h50);
    wait_cyc(1);
    // R5 masked source stays silent even with the register opened up
    do_cppr('hFF);
    pulse_evt(4'b0001);
    wait_cyc(3);
    chk(irq_out == 1'b0, "R5 masked until EOI", int'(irq_out), 0);
    do_eoi(1, 'hFF);
    wait_cyc(3);
    chk(irq_out == 1'b0, "R9 lost edge not replayed", int'(irq_out), 0);
    pulse_evt(4'b0001);
    wait_cyc(2);
    chk(irq_out == 1'b1, "R6 unmasked and re-armed", int'(irq_out), 1);
    do_ack(1, 'hFF);
    wait_cyc(2);
    chk(exp_q.size() == 0, "R3 all acks seen", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule